// File: doc/BRIEF.md
# Protected Range Access Guard

This block sits beside the core's load/store path and screens every physical access against one protected memory window. The window is set by two registers: a base register and a mask register, in the same layout as a variable memory-type range pair. When the core is in its privileged management mode, accesses inside the window are allowed. They take the memory type that is programmed in the base register.

When the core is outside management mode, any access that hits the window is denied. Its memory type is forced to uncacheable. Writes are discarded, reads return all ones, and a one-cycle violation pulse is raised. Accesses that miss the window pass through unchanged, with the caller's default memory type and the memory's read data.

The two registers can only be changed while the core is in management mode. Both reset to zero, so the window stays disabled until privileged code programs it.

Top module: `prot_range_guard`

## Requirements
- R1: After reset both registers are zero and no access hits the window.
- R2: An access hits when the valid bit (mask bit 11) is set and (address AND mask) equals (base AND mask), compared over address bits 31..12.
- R3: A hit while `mgmt_mode_i` is high is allowed, and `mem_type_o` equals base bits 7..0. The encodings are uncacheable 0x00, write-through 0x04 and write-back 0x06.
- R4: A hit while `mgmt_mode_i` is low is denied (`allow_o` low), and `mem_type_o` is 0x00 (uncacheable).
- R5: A read hit outside management mode returns all ones on `rdata_o`. In every other case `rdata_o` equals `mem_rdata_i`.
- R6: An access that misses the window, and any cycle without an access, gives `allow_o` high and `mem_type_o` equal to `dflt_type_i`.
- R7: A configuration write (`cfg_sel_i` 0 selects base, 1 selects mask) takes effect on the next cycle only if `mgmt_mode_i` is high. Otherwise it is dropped and both registers keep their values.
- R8: `violation_o` is high for exactly the one cycle after each denied access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_mode_i | input | 1 | Core is in privileged management mode |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 32 | Physical address of the access |
| dflt_type_i | input | 8 | Memory type used when the window is missed |
| mem_rdata_i | input | 64 | Read data from memory |
| cfg_we_i | input | 1 | Register write request |
| cfg_sel_i | input | 1 | 0 = base register, 1 = mask register |
| cfg_wdata_i | input | 32 | Register write data |
| hit_o | output | 1 | Access falls in the window |
| allow_o | output | 1 | Access may proceed to memory |
| mem_type_o | output | 8 | Memory type to use |
| rdata_o | output | 64 | Read data returned to the core |
| violation_o | output | 1 | One-cycle pulse after a denied access |

## Verification
Several rules are checked on every cycle:
- Outside management mode, a hit is denied and forced uncacheable.
- A read hit returns all ones.
- A miss passes the default type through.
- The violation pulse follows each denied access exactly one cycle later.
- The two registers never change without a privileged write.

Only the bench scenarios can show that the match rule selects the right addresses for a given base and mask. They also show that a clear valid bit disables the window, that a dropped configuration write leaves later decisions unchanged, and that a reprogrammed type field reaches the output.

// File: rtl/prg_pkg.sv
package prg_pkg;
  typedef enum logic [7:0] {
    MT_UC = 8'h00,
    MT_WC = 8'h01,
    MT_WT = 8'h04,
    MT_WP = 8'h05,
    MT_WB = 8'h06
  } mem_type_e;

  localparam int TYPE_W    = 8;
  localparam int VALID_BIT = 11;
endpackage

// File: rtl/prg_regs.sv
module prg_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_mode_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o
);
  logic [ADDR_W-1:0] base_q, mask_q;
  logic wr_ok;

  // privileged writes only
  assign wr_ok = cfg_we_i & mgmt_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (wr_ok) begin
      if (cfg_sel_i) mask_q <= cfg_wdata_i;
      else           base_q <= cfg_wdata_i;
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/prg_match.sv
module prg_match #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [ADDR_W-1:PAGE_SHIFT]   base_addr_i,
  input  logic [ADDR_W-1:PAGE_SHIFT]   mask_addr_i,
  input  logic                         valid_i,
  output logic                         match_o
);
  localparam int CMP_W = ADDR_W - PAGE_SHIFT;
  logic [CMP_W-1:0] bit_miss;

  for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
    assign bit_miss[i] = mask_addr_i[PAGE_SHIFT+i] &
                         (addr_i[PAGE_SHIFT+i] ^ base_addr_i[PAGE_SHIFT+i]);
  end

  assign match_o = valid_i & ~|bit_miss;
endmodule

// File: rtl/prg_policy.sv
module prg_policy
  import prg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_mode_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              match_i,
  input  logic [TYPE_W-1:0] range_type_i,
  input  logic [TYPE_W-1:0] dflt_type_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              hit_o,
  output logic              allow_o,
  output logic [TYPE_W-1:0] mem_type_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              violation_o
);
  logic deny, viol_q;

  assign hit_o = acc_valid_i & match_i;
  assign deny  = hit_o & ~mgmt_mode_i;

  always_comb begin
    allow_o    = 1'b1;
    mem_type_o = dflt_type_i;
    rdata_o    = mem_rdata_i;
    if (hit_o) begin
      if (mgmt_mode_i) begin
        mem_type_o = range_type_i;
      end else begin
        allow_o    = 1'b0;
        mem_type_o = TYPE_W'(MT_UC);
        if (!acc_write_i) rdata_o = {DATA_W{1'b1}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= deny;
  end

  assign violation_o = viol_q;
endmodule

// File: rtl/prot_range_guard.sv
module prot_range_guard
  import prg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_mode_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [7:0]        dflt_type_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              hit_o,
  output logic              allow_o,
  output logic [7:0]        mem_type_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              violation_o
);
  logic [ADDR_W-1:0] base_w, mask_w;
  logic              match_w;

  prg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mgmt_mode_i (mgmt_mode_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .base_o      (base_w),
    .mask_o      (mask_w)
  );

  prg_match #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
    .addr_i      (acc_addr_i),
    .base_addr_i (base_w[ADDR_W-1:PAGE_SHIFT]),
    .mask_addr_i (mask_w[ADDR_W-1:PAGE_SHIFT]),
    .valid_i     (mask_w[VALID_BIT]),
    .match_o     (match_w)
  );

  prg_policy #(.DATA_W(DATA_W)) u_policy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mgmt_mode_i  (mgmt_mode_i),
    .acc_valid_i  (acc_valid_i),
    .acc_write_i  (acc_write_i),
    .match_i      (match_w),
    .range_type_i (base_w[TYPE_W-1:0]),
    .dflt_type_i  (dflt_type_i),
    .mem_rdata_i  (mem_rdata_i),
    .hit_o        (hit_o),
    .allow_o      (allow_o),
    .mem_type_o   (mem_type_o),
    .rdata_o      (rdata_o),
    .violation_o  (violation_o)
  );
endmodule

// File: rtl/prg_guard_chk.sv
module prg_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mgmt_mode_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic              cfg_we_i,
  input logic [7:0]        dflt_type_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              hit_o,
  input logic              allow_o,
  input logic [7:0]        mem_type_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              violation_o,
  input logic [ADDR_W-1:0] base_w,
  input logic [ADDR_W-1:0] mask_w
);
  AST_PRIV_ALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && mgmt_mode_i |-> allow_o); // R3
  AST_UNPRIV_UC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !mgmt_mode_i |-> !allow_o && mem_type_o == 8'h00); // R4
  AST_RD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !mgmt_mode_i && !acc_write_i |-> rdata_o == {DATA_W{1'b1}}); // R5
  AST_MISS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> allow_o && mem_type_o == dflt_type_i && rdata_o == mem_rdata_i); // R6
  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && mgmt_mode_i) |=> $stable(base_w) && $stable(mask_w)); // R7
  AST_VIOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && hit_o && !mgmt_mode_i |=> violation_o); // R8
  AST_VIOL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && !mgmt_mode_i) |=> !violation_o); // R8
endmodule

bind prot_range_guard prg_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mgmt_mode_i (mgmt_mode_i),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .cfg_we_i    (cfg_we_i),
  .dflt_type_i (dflt_type_i),
  .mem_rdata_i (mem_rdata_i),
  .hit_o       (hit_o),
  .allow_o     (allow_o),
  .mem_type_o  (mem_type_o),
  .rdata_o     (rdata_o),
  .violation_o (violation_o),
  .base_w      (base_w),
  .mask_w      (mask_w)
);

// File: tb/prot_range_guard_tb.sv
module prot_range_guard_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mgmt_mode_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [7:0]  dflt_type_i = 8'h06;
  logic [63:0] mem_rdata_i = 64'h0123_4567_89ab_cdef;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        hit_o, allow_o, violation_o;
  logic [7:0]  mem_type_o;
  logic [63:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_base = '0, m_mask = '0;
  logic        m_viol = 1'b0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  prot_range_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mgmt_mode_i(mgmt_mode_i),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
    .dflt_type_i(dflt_type_i), .mem_rdata_i(mem_rdata_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .hit_o(hit_o),
    .allow_o(allow_o), .mem_type_o(mem_type_o), .rdata_o(rdata_o),
    .violation_o(violation_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [31:0] a);
    return acc_valid_i && m_mask[11] &&
           (((a ^ m_base) & m_mask & 32'hFFFF_F000) == 32'h0);
  endfunction

  // drive one cycle, compare every output against the model, advance the model
  task automatic step(input bit mode, input bit v, input bit wr, input logic [31:0] a,
                      input bit cwe = 1'b0, input bit csel = 1'b0,
                      input logic [31:0] cdata = '0);
    bit h, deny;
    logic [7:0]  et;
    logic [63:0] ed;
    string tt;
    mgmt_mode_i = mode; acc_valid_i = v; acc_write_i = wr; acc_addr_i = a;
    cfg_we_i = cwe; cfg_sel_i = csel; cfg_wdata_i = cdata;
    #4;
    h    = m_hit(a);
    deny = h && !mode;
    et   = !h ? dflt_type_i : (mode ? m_base[7:0] : 8'h00);
    ed   = (deny && !wr) ? '1 : mem_rdata_i;
    tt   = !h ? "R6" : (mode ? "R3" : "R4");
    chk(hit_o == h, "R2", "hit", 64'(hit_o), 64'(h));
    chk(allow_o == !deny, tt, "allow", 64'(allow_o), 64'(!deny));
    chk(mem_type_o == et, tt, "type", 64'(mem_type_o), 64'(et));
    chk(rdata_o == ed, "R5", "rdata", rdata_o, ed);
    chk(violation_o == m_viol, "R8", "violation", 64'(violation_o), 64'(m_viol));
    @(posedge clk_i);
    m_viol = deny;
    if (cwe && mode) begin
      if (csel) m_mask = cdata; else m_base = cdata;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ace_b00c;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: cleared registers never hit
    step(1'b1, 1'b1, 1'b0, 32'h0000_0000);
    #4; chk(hit_o == 1'b0, "R1", "hit after reset", 64'(hit_o), 64'h0);
    @(negedge clk_i);
    // R7: unprivileged configuration is dropped
    step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 32'h000A_0006);
    step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 32'hFFFF_0800);
    step(1'b0, 1'b1, 1'b0, 32'h000A_1234);
    acc_valid_i = 1'b1; acc_addr_i = 32'h000A_1234; #1;
    chk(hit_o == 1'b0, "R7", "dropped cfg write", 64'(hit_o), 64'h0);
    @(negedge clk_i);
    // privileged programming: 64 KiB window at 0x000A0000, write-back
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 32'h000A_0006);
    step(1'b1, 1'b1, 1'b0, 32'h000A_1234, 1'b1, 1'b1, 32'hFFFF_0800);
    step(1'b1, 1'b1, 1'b0, 32'h000A_1234);
    step(1'b1, 1'b1, 1'b1, 32'h000A_FFF0);
    step(1'b1, 1'b1, 1'b0, 32'h000B_0000);
    // R4 R5 R8: unprivileged hits
    step(1'b0, 1'b1, 1'b0, 32'h000A_8000);
    step(1'b0, 1'b1, 1'b1, 32'h000A_0010);
    step(1'b0, 1'b0, 1'b0, 32'h000A_0010);
    step(1'b0, 1'b1, 1'b0, 32'h0009_F000);
    step(1'b0, 1'b1, 1'b0, 32'h000A_4000);
    step(1'b0, 1'b1, 1'b0, 32'h000A_4000);
    // R3: retype to write-through
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 32'h000A_0004);
    step(1'b1, 1'b1, 1'b0, 32'h000A_2000);
    dflt_type_i = 8'h00;
    step(1'b1, 1'b1, 1'b0, 32'h1000_0000);
    // R7: unprivileged attempt to clear valid is dropped
    step(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 32'h0000_0000);
    step(1'b0, 1'b1, 1'b1, 32'h000A_3000);
    // R2: privileged valid clear disables the window
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 32'hFFFF_0000);
    step(1'b0, 1'b1, 1'b0, 32'h000A_3000);
    // re-enable with a 1 MiB window, then mixed traffic
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 32'hFFF0_0800);
    step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 32'h0030_0006);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mem_rdata_i = {lfsr, ~lfsr};
      step(lfsr[3], lfsr[5], lfsr[7],
           {10'h0, lfsr[16], 1'b1, lfsr[31:12] & 20'h3FFFF, 12'h0} | {20'h0, lfsr[11:0]});
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule